// File: doc/BRIEF.md
# Maskable and Non-Maskable Interrupt Conditioner

This block turns two active-low external interrupt pins into clean request lines for a processor core. Both raw pins are first brought into the clock domain through a flop chain. The maskable line can either follow the pin level or latch a falling edge. The trigger style is held in a configuration register that reset returns to level mode. The maskable request is also gated by an interrupt mask bit, which reset sets.

The non-maskable line always follows the pin level. After reset it is held off by its own mask bit. Software clears that bit with a one-cycle strobe. Once cleared, only reset can set it again. The core acknowledges a latched edge with a one-cycle pulse.

Top module: `intr_cond_top`

## Requirements
- R1: During and right after reset, both requests are low, the maskable trigger mode is level, and both mask bits are set, so a pin held low raises no request until its mask is cleared.
- R2: A level change on a pin reaches the request in level mode after SYNC_STAGES rising clock edges (two by default), and not one edge earlier.
- R3: In level mode (`cfg_edge`=0), the maskable request is high exactly while the synchronized pin is low and the mask is clear; nothing is latched, so the request drops SYNC_STAGES edges after the pin returns high.
- R4: In edge mode (`cfg_edge`=1), a high-to-low transition on the maskable pin sets a pending latch one edge after it is synchronized (three edges after the pin falls, by default), and the latch holds after the pin goes high again.
- R5: A one-cycle `edge_ack` pulse clears the pending latch; if a new falling edge is detected in the same cycle as the acknowledge, the latch stays set.
- R6: A maskable pin held low in edge mode counts as a single edge; after the acknowledge, no new request appears until the pin rises and falls again.
- R7: A configuration write that changes the trigger mode clears the pending latch.
- R8: While the maskable mask bit is set (`imask_val`=1 written with `imask_wr`), the maskable request is low; a latched edge survives the masked period and reappears when the mask is cleared.
- R9: The non-maskable request is high exactly while its synchronized pin is low and its mask is clear, with the same latency as R2.
- R10: A `nmi_unmask` strobe clears the non-maskable mask for good; nothing but reset sets it again.
- R11: In level mode `edge_ack` has no effect on the maskable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mi_pin_n | input | 1 | Raw maskable interrupt pin, active low |
| nmi_pin_n | input | 1 | Raw non-maskable interrupt pin, active low |
| cfg_wr | input | 1 | Write strobe for the trigger-mode bit |
| cfg_edge | input | 1 | Trigger mode: 0 level, 1 falling edge |
| imask_wr | input | 1 | Write strobe for the maskable mask bit |
| imask_val | input | 1 | New maskable mask value (1 = masked) |
| edge_ack | input | 1 | One-cycle acknowledge of a latched edge |
| nmi_unmask | input | 1 | One-cycle strobe that clears the non-maskable mask |
| mi_req | output | 1 | Maskable interrupt request |
| nmi_req | output | 1 | Non-maskable interrupt request |

## Verification
The bench uses the default SYNC_STAGES of 2. With that setting every latency is a few cycles, so each pin value can be held for four cycles and fully settle before it is checked. This keeps the full sweep short: both trigger modes, both maskable mask states, and all sixteen four-step pin sequences. The expected request for each step comes from a small running edge model. Directed cases then check the exact edge counts, the acknowledge-versus-new-edge collision, mode switches and the one-way non-maskable mask.

// File: rtl/intr_cond_pkg.sv
// Shared types for the interrupt conditioner.
package intr_cond_pkg;
    // Trigger style of the maskable line.
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

    // Shortest chain that still resolves metastability.
    localparam int unsigned SYNC_MIN = 2;
endpackage

// File: rtl/intr_sync.sv
// Flop chain that brings an asynchronous pin into the clock domain.
// Assumes: STAGES >= 2; reset loads IDLE so an idle pin is not seen as active.
module intr_sync #(
    parameter int unsigned STAGES = 2,
    parameter logic        IDLE   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw value one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

    initial begin
        if (STAGES < intr_cond_pkg::SYNC_MIN) $error("intr_sync: STAGES below minimum");
    end

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_chk
            // R2: every stage takes the previous stage's value one edge later.
            p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> chain[g] == $past(chain[g-1]));
        end
    endgenerate
endmodule

// File: rtl/intr_maskable.sv
// Maskable line: synchronizer, trigger-mode register, mask bit and edge latch.
// Assumes: edge_ack and cfg_wr are single-cycle strobes from the core.
module intr_maskable
    import intr_cond_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic cfg_wr,
    input  logic cfg_edge,
    input  logic imask_wr,
    input  logic imask_val,
    input  logic ack,
    output logic req
);
    logic       pin_s;
    logic       pin_prev;
    logic       fall;
    logic       pending;
    logic       imask;
    logic       mode_change;
    trig_mode_e mode;

    intr_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
    );

    // Trigger-mode register, level after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode <= TRIG_LEVEL;
        else if (cfg_wr) mode <= trig_mode_e'(cfg_edge);
    end

    // Mask bit, set after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)        imask <= 1'b1;
        else if (imask_wr) imask <= imask_val;
    end

    // Previous synchronized value, used for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_prev <= 1'b1;
        else        pin_prev <= pin_s;
    end

    assign fall        = pin_prev & ~pin_s;
    assign mode_change = cfg_wr && (trig_mode_e'(cfg_edge) != mode);

    // Edge latch: a new edge wins over a simultaneous acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pending <= 1'b0;
        else if (mode_change || mode == TRIG_LEVEL) pending <= 1'b0;
        else if (fall)                            pending <= 1'b1;
        else if (ack)                             pending <= 1'b0;
    end

    // Request: latch in edge mode, live level otherwise, both behind the mask.
    always_comb begin
        if (imask)                   req = 1'b0;
        else if (mode == TRIG_FALL)  req = pending;
        else                         req = ~pin_s;
    end

    // R1: reset leaves level mode and the mask set.
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mode == TRIG_LEVEL) && imask && !pending);
    // R8: a set mask keeps the request low.
    p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        imask |-> !req);
    // R3: nothing is latched in level mode.
    p_level_no_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_LEVEL) |-> !pending);
    // R4: a latched edge holds until acknowledge or mode change.
    p_edge_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && pending && !ack && !cfg_wr) |=> pending);
    // R5: acknowledge with no new edge clears the latch.
    p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == TRIG_FALL && ack && !fall) |=> !pending);
    // R7: a change of mode clears the latch.
    p_mode_switch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_change |=> !pending);
endmodule

// File: rtl/intr_nmi.sv
// Non-maskable line: synchronizer plus a one-way mask bit.
// Assumes: unmask is a single-cycle strobe; only reset sets the mask.
module intr_nmi #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic unmask,
    output logic req
);
    logic pin_s;
    logic mask;

    intr_sync #(.STAGES(STAGES), .IDLE(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
    );

    // One-way mask: reset sets it, the strobe clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      mask <= 1'b1;
        else if (unmask) mask <= 1'b0;
    end

    // Request follows the low level once unmasked.
    assign req = ~mask & ~pin_s;

    // R1: reset sets the mask.
    p_nmi_reset_r1: assert property (@(posedge clk) !rst_n |=> mask);
    // R9: the mask holds the request low.
    p_nmi_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !req);
    // R10: once cleared the mask stays cleared.
    p_nmi_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mask |=> !mask);
endmodule

// File: rtl/intr_cond_top.sv
// Top of the interrupt conditioner: one maskable and one non-maskable line.
// Assumes: pins are asynchronous, active low and idle high; strobes are one cycle.
module intr_cond_top #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mi_pin_n,
    input  logic nmi_pin_n,
    input  logic cfg_wr,
    input  logic cfg_edge,
    input  logic imask_wr,
    input  logic imask_val,
    input  logic edge_ack,
    input  logic nmi_unmask,
    output logic mi_req,
    output logic nmi_req
);
    intr_maskable #(.STAGES(SYNC_STAGES)) u_mask (
        .clk(clk), .rst_n(rst_n), .pin_n(mi_pin_n),
        .cfg_wr(cfg_wr), .cfg_edge(cfg_edge),
        .imask_wr(imask_wr), .imask_val(imask_val),
        .ack(edge_ack), .req(mi_req)
    );

    intr_nmi #(.STAGES(SYNC_STAGES)) u_nmi (
        .clk(clk), .rst_n(rst_n), .pin_n(nmi_pin_n),
        .unmask(nmi_unmask), .req(nmi_req)
    );

    // R1: no request leaves the block while reset is applied on the prior edge.
    p_quiet_reset_r1: assert property (@(posedge clk)
        !rst_n |=> !mi_req && !nmi_req);
endmodule

// File: tb/intr_cond_top_tb_top.sv
// Bench for intr_cond_top: directed corner cases plus a sweep of pin sequences.
module intr_cond_top_tb_top;
    logic clk = 1'b0;
    logic rst_n, mi_pin_n, nmi_pin_n, cfg_wr, cfg_edge;
    logic imask_wr, imask_val, edge_ack, nmi_unmask;
    logic mi_req, nmi_req;
    int   n_run = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    intr_cond_top #(.SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .mi_pin_n(mi_pin_n), .nmi_pin_n(nmi_pin_n),
        .cfg_wr(cfg_wr), .cfg_edge(cfg_edge), .imask_wr(imask_wr),
        .imask_val(imask_val), .edge_ack(edge_ack), .nmi_unmask(nmi_unmask),
        .mi_req(mi_req), .nmi_req(nmi_req)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input logic act, input logic exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_mode(input logic e);
        cfg_wr = 1'b1; cfg_edge = e; tick(1); cfg_wr = 1'b0;
    endtask

    task automatic set_imask(input logic m);
        imask_wr = 1'b1; imask_val = m; tick(1); imask_wr = 1'b0;
    endtask

    task automatic ack_pulse();
        edge_ack = 1'b1; tick(1); edge_ack = 1'b0;
    endtask

    initial begin
        #1600000;
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mi_pin_n = 1'b0; nmi_pin_n = 1'b0; cfg_wr = 1'b0; cfg_edge = 1'b0;
        imask_wr = 1'b0; imask_val = 1'b0; edge_ack = 1'b0; nmi_unmask = 1'b0;
        tick(3);
        check(mi_req, 1'b0, "R1 mi in reset");
        check(nmi_req, 1'b0, "R1 nmi in reset");
        rst_n = 1'b1;
        tick(5);
        check(mi_req, 1'b0, "R1 mi masked after reset");
        check(nmi_req, 1'b0, "R1 nmi masked after reset");
        set_imask(1'b0);
        check(mi_req, 1'b1, "R1 level mode default");
        nmi_unmask = 1'b1; tick(1); nmi_unmask = 1'b0;
        check(nmi_req, 1'b1, "R9 nmi after unmask");

        // R2/R3: level latency and no latch
        mi_pin_n = 1'b1; nmi_pin_n = 1'b1; tick(4);
        check(mi_req, 1'b0, "R3 idle");
        mi_pin_n = 1'b0; tick(1);
        check(mi_req, 1'b0, "R2 one edge early");
        tick(1);
        check(mi_req, 1'b1, "R2 after two edges");
        mi_pin_n = 1'b1; tick(1);
        check(mi_req, 1'b1, "R3 release one edge");
        tick(1);
        check(mi_req, 1'b0, "R3 no latch");

        // R9/R10: nmi latency and sticky unmask
        nmi_pin_n = 1'b0; tick(1);
        check(nmi_req, 1'b0, "R9 one edge early");
        tick(1);
        check(nmi_req, 1'b1, "R9 after two edges");
        nmi_unmask = 1'b1; tick(1); nmi_unmask = 1'b0; tick(20);
        check(nmi_req, 1'b1, "R10 stays unmasked");
        nmi_pin_n = 1'b1; tick(2);
        check(nmi_req, 1'b0, "R9 release");

        // R11: ack ignored in level mode
        mi_pin_n = 1'b0; tick(3);
        ack_pulse();
        check(mi_req, 1'b1, "R11 ack in level mode");
        mi_pin_n = 1'b1; tick(3);

        // R4: edge mode latch
        set_mode(1'b1); tick(2);
        mi_pin_n = 1'b0; tick(2);
        check(mi_req, 1'b0, "R4 two edges");
        tick(1);
        check(mi_req, 1'b1, "R4 three edges");
        mi_pin_n = 1'b1; tick(5);
        check(mi_req, 1'b1, "R4 held after release");
        ack_pulse();
        check(mi_req, 1'b0, "R5 ack clears");

        // R6: held low counts once
        mi_pin_n = 1'b0; tick(6);
        check(mi_req, 1'b1, "R6 held low sets");
        ack_pulse(); tick(6);
        check(mi_req, 1'b0, "R6 no re-request");
        mi_pin_n = 1'b1; tick(4);

        // R5: ack collides with new edge
        mi_pin_n = 1'b0; tick(2);
        edge_ack = 1'b1; tick(1); edge_ack = 1'b0;
        check(mi_req, 1'b1, "R5 new edge beats ack");

        // R8: mask keeps latch
        set_imask(1'b1);
        check(mi_req, 1'b0, "R8 masked");
        tick(3);
        set_imask(1'b0);
        check(mi_req, 1'b1, "R8 latch survives mask");

        // R7: mode switch clears latch
        mi_pin_n = 1'b1; tick(4);
        set_mode(1'b0);
        check(mi_req, 1'b0, "R7 switch to level");
        set_mode(1'b1);
        check(mi_req, 1'b0, "R7 back to edge");

        // Sweep: modes x masks x all four-step pin sequences
        for (int md = 0; md < 2; md++) begin
            set_mode(md[0]);
            for (int mk = 0; mk < 2; mk++) begin
                set_imask(mk[0]);
                for (int pat = 0; pat < 16; pat++) begin
                    logic prev, pend, v, exp;
                    mi_pin_n = 1'b1; tick(4);
                    ack_pulse();
                    prev = 1'b1; pend = 1'b0;
                    for (int k = 0; k < 4; k++) begin
                        v = pat[k];
                        mi_pin_n = v; tick(4);
                        if (prev && !v) pend = 1'b1;
                        prev = v;
                        exp = md[0] ? (pend & ~mk[0]) : (~v & ~mk[0]);
                        check(mi_req, exp, md[0] ? "R4 sweep edge" : "R3 sweep level");
                    end
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule